// File: doc/BRIEF.md
# Response Signature Compactor

This block compacts test responses into one signature while a self-test runs. Each capture cycle folds a wide response word into a shift register that has linear feedback. The word can come from scan-chain outputs, from regular outputs, or from both. Because of the feedback, one wrong response bit in any cycle leaves the final signature wrong. Aliasing is the chance that a faulty run still ends on the good value. For a 16-bit register that chance is 1 in 65,536.

An optional front stage folds each adjacent pair of response bits through an XOR gate. This halves the register width, which saves area, but it raises the aliasing risk: an error is masked when both bits of a pair are wrong in the same cycle. The block takes a fixed number of captures. After that, the signature is either compared on chip against a golden value, which is given as a parameter and comes from fault-free simulation, or shifted out serially, most significant bit first.

Top module: `sig_compactor`

## Requirements
- R1: `clear` is synchronous and has priority over every other input. On the next edge it sets the register to all zeros, zeroes the capture count, and drops `verdict_valid` and `pass`. The same holds on reset.
- R2: A capture cycle is one with `capture` high and both `clear` and `shift_en` low, taken while fewer than NCAP captures have been counted. On each such cycle the register becomes `(S << 1) ^ (S[MSB] ? TAPS : 0) ^ V`. When REDUCE=1, V bit i is `resp[2i] ^ resp[2i+1]` and the register is IN_W/2 bits wide. When REDUCE=0, V equals `resp` and the register is IN_W bits wide.
- R3: With `clear`, `capture` and `shift_en` all low, the register holds its value.
- R4: Once NCAP captures have been counted, further `capture` pulses are ignored until the next `clear`.
- R5: A `compare` pulse that arrives when the count equals NCAP sets `verdict_valid` on the next edge. On that edge `pass` becomes 1 exactly when the register equals GOLDEN. A `compare` that arrives before NCAP captures is ignored.
- R6: Once `verdict_valid` is set, it and `pass` hold their values until `clear`. Later `compare`, `capture` or shift cycles do not change them. `pass` is 0 whenever `verdict_valid` is 0.
- R7: `sig_serial` always shows the register MSB. Each cycle with `shift_en` high and `clear` low shifts the register left by one and fills bit 0 with zero, so the signature comes out MSB first. Shifting takes priority over capture and leaves the count unchanged.
- R8: One flipped response bit in one cycle makes the final signature differ from the fault-free one. In reduced mode, flipping both bits of one pair in the same cycle leaves the signature unchanged.
- R9: An unknown value on `resp` during a `capture` cycle is a design error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Start of a run: zeroes register, count and verdict |
| capture | input | 1 | Fold `resp` into the register this cycle |
| resp | input | IN_W | Response word from the device under test |
| shift_en | input | 1 | Shift the signature out serially |
| compare | input | 1 | Request the on-chip check against GOLDEN |
| sig_serial | output | 1 | Register MSB, the serial signature stream |
| verdict_valid | output | 1 | The compare result is available |
| pass | output | 1 | Signature matched GOLDEN (only meaningful when `verdict_valid` is high) |

## Verification
A wrong register bit is never corrected, so it always shows up at the end of the run. A `compare` shows it as `pass` low one cycle after the request. Shifting the signature out shows it within SIG_W cycles, at the exact bit position. A capture count that is off shows up as a signature shifted by one extra or one missing step, or as a compare that is never honoured. The bench computes every signature itself from the R2 formula. It checks both widths: single-bit faults must be caught, and reduced mode must mask paired faults.

// File: rtl/sig_compactor.sv
module sig_compactor #(
  parameter int IN_W   = 32,
  parameter bit REDUCE = 1'b1,
  parameter int SIG_W  = REDUCE ? IN_W / 2 : IN_W,
  parameter int NCAP   = 8,
  parameter logic [SIG_W-1:0] TAPS   = {{(SIG_W-16){1'b0}}, 16'h1021},
  parameter logic [SIG_W-1:0] GOLDEN = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            capture,
  input  logic [IN_W-1:0] resp,
  input  logic            shift_en,
  input  logic            compare,
  output logic            sig_serial,
  output logic            verdict_valid,
  output logic            pass
);
  localparam int CW = $clog2(NCAP + 1);

  logic [SIG_W-1:0] sig_q, folded, fb;
  logic [CW-1:0]    cnt_q;
  logic             full, valid_q, pass_q;

  genvar gi;
  generate
    for (gi = 0; gi < SIG_W; gi++) begin : g_fold
      if (REDUCE) begin : g_pair
        assign folded[gi] = resp[2*gi] ^ resp[2*gi+1];
      end else begin : g_direct
        assign folded[gi] = resp[gi];
      end
    end
  endgenerate

  assign full = (cnt_q == CW'(NCAP));
  assign fb   = sig_q[SIG_W-1] ? TAPS : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      sig_q <= '0;
      cnt_q <= '0;
    end else if (shift_en) begin
      sig_q <= {sig_q[SIG_W-2:0], 1'b0};
    end else if (capture && !full) begin
      sig_q <= {sig_q[SIG_W-2:0], 1'b0} ^ fb ^ folded;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pass_q  <= 1'b0;
    end else if (clear) begin
      valid_q <= 1'b0;
      pass_q  <= 1'b0;
    end else if (compare && full && !valid_q) begin
      valid_q <= 1'b1;
      pass_q  <= (sig_q == GOLDEN);
    end
  end

  assign sig_serial    = sig_q[SIG_W-1];
  assign verdict_valid = valid_q;
  assign pass          = pass_q;

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sig_q == '0 && cnt_q == '0 && !verdict_valid && !pass));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !capture && !shift_en) |=> $stable(sig_q));

  // R4
  sat_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clear && !shift_en) |=> ($stable(sig_q) && $stable(cnt_q)));

  // R5
  early_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (compare && !full && !verdict_valid && !clear) |=> !verdict_valid);

  // R6
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && !clear) |=> (verdict_valid && $stable(pass)));

  // R6
  pass_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid |-> !pass);

  // R7
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clear) |=>
      (sig_q == {$past(sig_q[SIG_W-2:0]), 1'b0} && $stable(cnt_q)));

  // R9
  no_x_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !$isunknown(resp));
endmodule

// File: tb/tb_sig_compactor.sv
module tb_sig_compactor;
  localparam int CLK_PERIOD = 10;
  localparam int NCAP = 8;
  localparam logic [15:0] T16 = 16'h1021;
  localparam logic [31:0] T32 = 32'h04C11DB7;

  function automatic logic [31:0] pat(input int k);
    return 32'hA5C30F1E ^ (32'h9E3779B9 * (k + 1));
  endfunction

  function automatic logic [15:0] fold(input logic [31:0] r);
    logic [15:0] v;
    for (int i = 0; i < 16; i++) v[i] = r[2*i] ^ r[2*i+1];
    return v;
  endfunction

  function automatic logic [15:0] st16(input logic [15:0] s, input logic [31:0] r);
    return {s[14:0], 1'b0} ^ (s[15] ? T16 : 16'h0) ^ fold(r);
  endfunction

  function automatic logic [31:0] st32(input logic [31:0] s, input logic [31:0] r);
    return {s[30:0], 1'b0} ^ (s[31] ? T32 : 32'h0) ^ r;
  endfunction

  function automatic logic [15:0] gold16();
    logic [15:0] s = '0;
    for (int k = 0; k < NCAP; k++) s = st16(s, pat(k));
    return s;
  endfunction

  function automatic logic [31:0] gold32();
    logic [31:0] s = '0;
    for (int k = 0; k < NCAP; k++) s = st32(s, pat(k));
    return s;
  endfunction

  localparam logic [15:0] G16 = gold16();
  localparam logic [31:0] G32 = gold32();

  logic clk = 0, rst_n = 0, clear = 0, capture = 0, shift_en = 0, compare = 0;
  logic [31:0] resp = '0;
  logic ser16, val16, pass16, ser32, val32, pass32;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_compactor #(.IN_W(32), .REDUCE(1'b1), .NCAP(NCAP), .TAPS(T16), .GOLDEN(G16)) dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .capture(capture), .resp(resp),
    .shift_en(shift_en), .compare(compare), .sig_serial(ser16),
    .verdict_valid(val16), .pass(pass16));

  sig_compactor #(.IN_W(32), .REDUCE(1'b0), .NCAP(NCAP), .TAPS(T32), .GOLDEN(G32)) dut_nr (
    .clk(clk), .rst_n(rst_n), .clear(clear), .capture(capture), .resp(resp),
    .shift_en(shift_en), .compare(compare), .sig_serial(ser32),
    .verdict_valid(val32), .pass(pass32));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_clear();
    clear = 1; @(negedge clk); clear = 0;
  endtask

  task automatic run(input int fc, input logic [31:0] fm,
                     output logic [15:0] e16, output logic [31:0] e32);
    e16 = '0; e32 = '0;
    do_clear();
    for (int k = 0; k < NCAP; k++) begin
      resp = pat(k) ^ ((k == fc) ? fm : 32'h0);
      e16 = st16(e16, resp); e32 = st32(e32, resp);
      capture = 1; @(negedge clk);
    end
    capture = 0; resp = '0;
  endtask

  task automatic read_sig(output logic [15:0] s16, output logic [31:0] s32);
    s16 = '0; s32 = '0; shift_en = 1;
    for (int i = 0; i < 32; i++) begin
      if (i < 16) s16 = {s16[14:0], ser16};
      s32 = {s32[30:0], ser32};
      @(negedge clk);
    end
    shift_en = 0;
  endtask

  task automatic do_compare();
    compare = 1; @(negedge clk); compare = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] e16, s16;
    logic [31:0] e32, s32;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {ser16, val16, pass16, ser32, val32, pass32}, 32'h0);

    // R5 compare before NCAP ignored
    do_clear();
    resp = pat(0); capture = 1; @(negedge clk); capture = 0;
    do_compare();
    chk("R5", {val16, val32}, 32'h0);

    // R2 R5 fault-free run
    run(-1, 0, e16, e32);
    chk("R2", e16, G16);
    do_compare();
    chk("R5", {val16, pass16, val32, pass32}, 32'hF);
    // R6 verdict holds through capture/compare
    resp = 32'hFFFF_FFFF; capture = 1; compare = 1; @(negedge clk);
    capture = 0; compare = 0;
    chk("R6", {val16, pass16, val32, pass32}, 32'hF);
    // R4 R7 signature readout unchanged by extra capture
    read_sig(s16, s32);
    chk("R4", s16, G16);
    chk("R7", s32, G32);
    chk("R7", {ser16, ser32}, 32'h0);
    chk("R6", {val16, pass16, val32, pass32}, 32'hF);
    do_clear();
    chk("R1", {val16, pass16, val32, pass32}, 32'h0);

    // R8 single-bit faults across all cycles and a bit sweep
    for (int c = 0; c < NCAP; c++) begin
      for (int b = 0; b < 32; b += 7) begin
        run(c, 32'h1 << b, e16, e32);
        do_compare();
        chk("R8", {val16, pass16, val32, pass32}, 32'hA);
        read_sig(s16, s32);
        chk("R2", s16, e16);
        chk("R2", s32, e32);
        chk("R8", 32'(s16 != G16), 32'h1);
      end
    end

    // R8 paired fault masked in reduced mode only
    run(3, 32'h30, e16, e32);
    do_compare();
    chk("R8", {pass16, pass32}, 32'h2);
    read_sig(s16, s32);
    chk("R8", s16, G16);
    chk("R2", s32, e32);

    // R3 idle hold, R7 shift priority over capture
    run(-1, 0, e16, e32);
    repeat (3) @(negedge clk);
    do_clear();
    resp = pat(0); capture = 1; @(negedge clk);
    e16 = st16(16'h0, pat(0));
    shift_en = 1; @(negedge clk); shift_en = 0; capture = 0;
    e16 = {e16[14:0], 1'b0};
    repeat (2) @(negedge clk);
    read_sig(s16, s32);
    chk("R3", s16, e16);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule